// File: doc/BRIEF.md
# Decode-Stage Hazard and Forwarding Controller

This block holds the hazard control for a five-stage in-order integer pipeline with the stages fetch, decode with register read, execute, memory access and writeback. Conditional branches and jumps are resolved in decode. Because the branch comparator sits in decode, operand bypassing also lands in decode. Two bypass sources exist: the result leaving the execute stage and the result leaving the memory stage. The controller compares the two source register numbers of the decoding instruction with the destinations of the older instructions in execute and memory. It then chooses a bypass source for each operand.

A load that is still in execute cannot supply its data in time. When such a load feeds the decoding instruction, the controller holds the PC and the fetch/decode register for one cycle and puts a bubble into execute. On the next cycle the value comes from the memory-stage bypass. Fetch always assumes fall-through. When decode finds a taken branch or a jump, the controller selects the target as the next PC and sets the nop bit of the fetch/decode register, which discards the one wrongly fetched instruction. The datapath reports operand equality after bypassing, and each stage reports its nop bit. The controller has no state of its own. Clock and reset serve only to sample its built-in checks.

Top module: `hzc_ctrl`

## Requirements
- R1: A source register number of zero always selects the register file (code 0) for that operand, whatever the producers write.
- R2: When the live execute-stage producer writes a nonzero register that an operand reads, that operand selects the execute bypass (code 1).
- R3: When only the live memory-stage producer writes a nonzero register that an operand reads, that operand selects the memory bypass (code 2).
- R4: When the execute and memory producers both write the register an operand reads, the execute bypass (code 1) wins.
- R5: A producer whose nop bit is 1 or whose write enable is 0 is ignored by every match, both for forwarding and for stalling.
- R6: A live load in execute whose destination matches either nonzero decode source, with decode not a nop, raises `hold_fetch` and `bubble_ex` together. A load that has reached memory causes no stall and is forwarded with code 2.
- R7: A taken branch raises `pc_take_target` and `flush_fetch` together in the same cycle. Taken means `id_is_branch`=1 with equal operands when `id_branch_ne`=0, or unequal operands when `id_branch_ne`=1.
- R8: A branch whose condition fails raises neither `pc_take_target` nor `flush_fetch`.
- R9: A jump in decode (`id_is_jump`=1) redirects and flushes in the same way as a taken branch.
- R10: When decode holds a nop, or while `hold_fetch` is high, `pc_take_target` stays 0. A decode nop also never raises `hold_fetch`. The forwarding selects do not depend on the decode nop bit.
- R11: Each forwarding select only ever takes the codes 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling the built-in checks |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_nop | input | 1 | Decode stage holds no valid instruction |
| id_src_a | input | 5 | First source register number in decode |
| id_src_b | input | 5 | Second source register number in decode |
| id_is_branch | input | 1 | Decode holds a conditional branch |
| id_branch_ne | input | 1 | Branch condition is not-equal (0: equal) |
| id_is_jump | input | 1 | Decode holds an unconditional jump-and-link |
| id_opnds_eq | input | 1 | Bypassed decode operands compare equal |
| ex_nop | input | 1 | Execute stage holds no valid instruction |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_wr_en | input | 1 | Execute instruction writes a register |
| ex_is_load | input | 1 | Execute instruction is a load |
| mem_nop | input | 1 | Memory stage holds no valid instruction |
| mem_dst | input | 5 | Destination register of the memory instruction |
| mem_wr_en | input | 1 | Memory instruction writes a register |
| fwd_sel_a | output | 2 | Bypass source for operand A: 0 file, 1 execute, 2 memory |
| fwd_sel_b | output | 2 | Bypass source for operand B, same codes |
| hold_fetch | output | 1 | Hold PC and the fetch/decode register |
| bubble_ex | output | 1 | Load a nop into the decode/execute register |
| flush_fetch | output | 1 | Set the fetch/decode nop bit for the next cycle |
| pc_take_target | output | 1 | Next PC is the decode target (0: PC+4) |

## Verification
Any wrong internal match shows up at the port in the same cycle, because every output is combinational. A dropped x0 or nop qualifier gives a nonzero select code. A missed load match lets `hold_fetch` stay low while a bypass code still names execute. A broken priority gives code 2 where code 1 is expected. Because nothing is stored, each vector is checked on its own, and a single wrong row points at the faulty qualifier.

// File: rtl/hzc_pkg.sv
package hzc_pkg;
  localparam int REG_AW_DEF = 5;
  localparam int N_OPND     = 2;

  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EX  = 2'd1,
    SRC_MEM = 2'd2
  } opnd_src_e;
endpackage

// File: rtl/hzc_opnd_fwd.sv
module hzc_opnd_fwd
  import hzc_pkg::*;
#(
  parameter int REG_AW = REG_AW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REG_AW-1:0] rs,
  input  logic              ex_live,
  input  logic [REG_AW-1:0] ex_rd,
  input  logic              mem_live,
  input  logic [REG_AW-1:0] mem_rd,
  output opnd_src_e         sel,
  output logic              ex_match
);
  logic rs_nonzero;
  logic mem_match;

  always_comb begin
    rs_nonzero = (rs != '0);
    ex_match   = rs_nonzero && ex_live  && (ex_rd  == rs);
    mem_match  = rs_nonzero && mem_live && (mem_rd == rs);
    if (ex_match)       sel = SRC_EX;
    else if (mem_match) sel = SRC_MEM;
    else                sel = SRC_RF;
  end

  // R1: the zero register never takes a bypass
  p_x0_rf_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (rs == '0) |-> (sel == SRC_RF));

  // R11: only the three defined codes appear
  p_sel_legal_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sel != opnd_src_e'(2'd3));

  // R4: with both producers matching, execute wins
  p_ex_prio_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_match && mem_live && (mem_rd == ex_rd)) |-> (sel == SRC_EX));
endmodule

// File: rtl/hzc_load_stall.sv
module hzc_load_stall #(
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             id_nop,
  input  logic             ex_is_load,
  input  logic [N_SRC-1:0] ex_match,
  output logic             stall
);
  always_comb begin
    stall = !id_nop && ex_is_load && (|ex_match);
  end

  // R10: an empty decode slot never holds fetch
  p_nop_no_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    id_nop |-> !stall);
endmodule

// File: rtl/hzc_redirect.sv
module hzc_redirect (
  input  logic clk,
  input  logic rst_n,
  input  logic id_nop,
  input  logic stall,
  input  logic is_branch,
  input  logic branch_ne,
  input  logic opnds_eq,
  input  logic is_jump,
  output logic redirect
);
  logic cond_met;

  always_comb begin
    cond_met = opnds_eq ^ branch_ne;
    redirect = !id_nop && !stall && (is_jump || (is_branch && cond_met));
  end

  // R10: a stalled decode may not steer fetch
  p_stall_blocks_redirect_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !redirect);

  // R8: a failed branch with no jump stays sequential
  p_not_taken_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && !is_jump && (opnds_eq == branch_ne)) |-> !redirect);
endmodule

// File: rtl/hzc_ctrl.sv
module hzc_ctrl
  import hzc_pkg::*;
#(
  parameter int REG_AW = REG_AW_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_nop,
  input  logic [REG_AW-1:0] id_src_a,
  input  logic [REG_AW-1:0] id_src_b,
  input  logic              id_is_branch,
  input  logic              id_branch_ne,
  input  logic              id_is_jump,
  input  logic              id_opnds_eq,
  input  logic              ex_nop,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_wr_en,
  input  logic              ex_is_load,
  input  logic              mem_nop,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_wr_en,
  output logic [1:0]        fwd_sel_a,
  output logic [1:0]        fwd_sel_b,
  output logic              hold_fetch,
  output logic              bubble_ex,
  output logic              flush_fetch,
  output logic              pc_take_target
);
  logic                ex_live;
  logic                mem_live;
  logic [REG_AW-1:0]   src    [N_OPND];
  opnd_src_e           sel    [N_OPND];
  logic [N_OPND-1:0]   ex_hit;
  logic                stall;
  logic                redirect;

  always_comb begin
    ex_live  = !ex_nop  && ex_wr_en;
    mem_live = !mem_nop && mem_wr_en;
    src[0]   = id_src_a;
    src[1]   = id_src_b;
  end

  for (genvar g = 0; g < N_OPND; g++) begin : g_opnd
    hzc_opnd_fwd #(.REG_AW(REG_AW)) u_fwd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rs       (src[g]),
      .ex_live  (ex_live),
      .ex_rd    (ex_dst),
      .mem_live (mem_live),
      .mem_rd   (mem_dst),
      .sel      (sel[g]),
      .ex_match (ex_hit[g])
    );
  end

  hzc_load_stall #(.N_SRC(N_OPND)) u_stall (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_nop     (id_nop),
    .ex_is_load (ex_is_load),
    .ex_match   (ex_hit),
    .stall      (stall)
  );

  hzc_redirect u_redir (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_nop    (id_nop),
    .stall     (stall),
    .is_branch (id_is_branch),
    .branch_ne (id_branch_ne),
    .opnds_eq  (id_opnds_eq),
    .is_jump   (id_is_jump),
    .redirect  (redirect)
  );

  always_comb begin
    fwd_sel_a      = sel[0];
    fwd_sel_b      = sel[1];
    hold_fetch     = stall;
    bubble_ex      = stall;
    flush_fetch    = redirect;
    pc_take_target = redirect;
  end

  // R6: hold and bubble always travel together
  p_bubble_tracks_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fetch == bubble_ex);

  // R7: every redirect discards the slot fetched behind it
  p_flush_tracks_pc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_fetch == pc_take_target);

  // R5: a killed execute producer cannot stall
  p_dead_ex_no_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_nop || !ex_wr_en) |-> !hold_fetch);
endmodule

// File: tb/hzc_ctrl_bench.sv
module hzc_ctrl_bench;
  typedef struct packed {
    logic       idn;
    logic [4:0] rs1;
    logic [4:0] rs2;
    logic       br;
    logic       ne;
    logic       jal;
    logic       eq;
    logic       exn;
    logic [4:0] exrd;
    logic       exw;
    logic       exl;
    logic       memn;
    logic [4:0] memrd;
    logic       memw;
    logic [1:0] ea;
    logic [1:0] eb;
    logic       es;
    logic       er;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  // idn rs1 rs2 br ne jal eq | exn exrd exw exl | memn memrd memw | ea eb es er | req
  localparam vec_t VECS [NV] = '{
    '{0, 1, 2, 0,0,0,0, 0, 1,1,0, 0, 9,1, 1,0,0,0, 2},  // R2 operand A from execute
    '{0, 3, 4, 0,0,0,0, 0, 4,1,0, 0, 9,1, 0,1,0,0, 2},  // R2 operand B from execute
    '{0, 3, 8, 0,0,0,0, 0, 7,1,0, 0, 3,1, 2,0,0,0, 3},  // R3 memory bypass
    '{0, 5, 5, 0,0,0,0, 0, 5,1,0, 0, 5,1, 1,1,0,0, 4},  // R4 execute wins
    '{0, 0, 0, 0,0,0,0, 0, 0,1,0, 0, 0,1, 0,0,0,0, 1},  // R1 x0 never forwarded
    '{0, 1, 2, 0,0,0,0, 1, 1,1,0, 0, 2,0, 0,0,0,0, 5},  // R5 nop ex, no-write mem
    '{0, 1, 2, 0,0,0,0, 0, 1,0,0, 0, 1,1, 2,0,0,0, 5},  // R5 no-write ex falls to mem
    '{0, 3, 6, 0,0,0,0, 0, 6,1,1, 0, 9,1, 0,1,1,0, 6},  // R6 load-use stall
    '{0, 6, 2, 1,0,0,1, 0, 6,1,1, 0, 9,1, 1,0,1,0, 10}, // R10 stall blocks redirect
    '{0, 1, 2, 1,0,0,1, 0, 9,1,0, 0, 9,1, 0,0,0,1, 7},  // R7 BEQ equal
    '{0, 1, 2, 1,0,0,0, 0, 9,1,0, 0, 9,1, 0,0,0,0, 8},  // R8 BEQ unequal
    '{0, 1, 2, 1,1,0,0, 0, 9,1,0, 0, 9,1, 0,0,0,1, 7},  // R7 BNE unequal
    '{0, 1, 2, 1,1,0,1, 0, 9,1,0, 0, 9,1, 0,0,0,0, 8},  // R8 BNE equal
    '{0, 0, 0, 0,0,1,0, 0, 9,1,0, 0, 9,1, 0,0,0,1, 9},  // R9 jump
    '{1, 6, 0, 0,0,1,0, 0, 6,1,1, 0, 9,1, 1,0,0,0, 10}, // R10 decode nop
    '{0, 6, 2, 0,0,0,0, 1, 6,1,1, 0, 9,1, 0,0,0,0, 5},  // R5 dead load no stall
    '{0, 6, 2, 0,0,0,0, 0, 9,1,0, 0, 6,1, 2,0,0,0, 6}   // R6 load in memory forwards
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       id_nop, id_is_branch, id_branch_ne, id_is_jump, id_opnds_eq;
  logic [4:0] id_src_a, id_src_b, ex_dst, mem_dst;
  logic       ex_nop, ex_wr_en, ex_is_load, mem_nop, mem_wr_en;
  logic [1:0] fwd_sel_a, fwd_sel_b;
  logic       hold_fetch, bubble_ex, flush_fetch, pc_take_target;
  int         n_chk = 0;
  int         n_bad = 0;
  int         cyc   = 0;

  always #10 clk = ~clk;

  hzc_ctrl u_hzc_ctrl (
    .clk(clk), .rst_n(rst_n), .id_nop(id_nop), .id_src_a(id_src_a),
    .id_src_b(id_src_b), .id_is_branch(id_is_branch), .id_branch_ne(id_branch_ne),
    .id_is_jump(id_is_jump), .id_opnds_eq(id_opnds_eq), .ex_nop(ex_nop),
    .ex_dst(ex_dst), .ex_wr_en(ex_wr_en), .ex_is_load(ex_is_load),
    .mem_nop(mem_nop), .mem_dst(mem_dst), .mem_wr_en(mem_wr_en),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b), .hold_fetch(hold_fetch),
    .bubble_ex(bubble_ex), .flush_fetch(flush_fetch), .pc_take_target(pc_take_target)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    id_nop = v.idn; id_src_a = v.rs1; id_src_b = v.rs2;
    id_is_branch = v.br; id_branch_ne = v.ne; id_is_jump = v.jal; id_opnds_eq = v.eq;
    ex_nop = v.exn; ex_dst = v.exrd; ex_wr_en = v.exw; ex_is_load = v.exl;
    mem_nop = v.memn; mem_dst = v.memrd; mem_wr_en = v.memw;
    #5;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 5000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    vec_t idle;
    idle = '0;
    idle.idn = 1'b1; idle.exn = 1'b1; idle.memn = 1'b1;
    rst_n = 1'b0;
    apply(idle);
    // reset state: idle pipeline drives every control low (R10, R11)
    check("R10 reset hold", int'(hold_fetch), 0);
    check("R10 reset redirect", int'(pc_take_target), 0);
    check("R11 reset sel", int'({fwd_sel_a, fwd_sel_b}), 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      apply(VECS[i]);
      t = $sformatf("R%0d vec%0d", VECS[i].req, i);
      check({t, " sel_a"}, int'(fwd_sel_a), int'(VECS[i].ea));
      check({t, " sel_b"}, int'(fwd_sel_b), int'(VECS[i].eb));
      check({t, " hold"}, int'(hold_fetch), int'(VECS[i].es));
      check({t, " bubble"}, int'(bubble_ex), int'(VECS[i].es));
      check({t, " pc_sel"}, int'(pc_take_target), int'(VECS[i].er));
      check({t, " flush"}, int'(flush_fetch), int'(VECS[i].er));
    end

    // R2 and R3 across every nonzero register number
    for (int r = 1; r < 32; r++) begin
      vec_t v;
      v = '0;
      v.rs1 = 5'(r); v.exrd = 5'(r); v.exw = 1'b1; v.memn = 1'b1;
      apply(v);
      check($sformatf("R2 reg%0d", r), int'(fwd_sel_a), 1);
      v.exn = 1'b1; v.memn = 1'b0; v.memrd = 5'(r); v.memw = 1'b1;
      apply(v);
      check($sformatf("R3 reg%0d", r), int'(fwd_sel_a), 2);
    end

    // R1 corner: x0 source with a load writing x0 causes no stall
    begin
      vec_t v;
      v = '0;
      v.exw = 1'b1; v.exl = 1'b1; v.memn = 1'b1;
      apply(v);
      check("R1 x0 load no stall", int'(hold_fetch), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule